// File: doc/BRIEF.md
# Drive Reset Sequencer

This block produces the two reset lines of a storage drive controller. The first line resets the drive's external reset IC. It is pulled low while either a software-controlled system-reset bit or the host's hardware reset pin is low, and it floats otherwise. The second line resets the local microcontroller. It follows the power-on reset input directly, and it also carries a stretched low pulse whenever the host writes the soft-reset command byte. That same command raises an interrupt to the microcontroller, and the interrupt holds until firmware clears it.

Both lines are open-drain. Each one is modelled as an output enable plus a data value tied low, so the pin is either driven low or released. The power-on reset input also resets the block's own state. It is asserted asynchronously, and its release passes through a short synchronizer chain. The pulse length defaults to 33,868 clock cycles, which is about 1 ms at a 33.8688 MHz reference. The power-on input is expected to stay low for at least 1 µs after supply ramp.

Top module: `drive_reset_seq`

## Requirements
- R1: `drv_rst_oe` is 1 in the same cycle that `sys_rst_bit` is 0 or `host_rst_n` is 0.
- R2: `drv_rst_oe` is 0 whenever `sys_rst_bit` and `host_rst_n` are both 1. `drv_rst_o` and `cpu_rst_o` are always 0.
- R3: A clock edge that samples `cmd_wr`=1 with `cmd_byte`=0x08 sets `cpu_rst_oe` to 1 from the next cycle, for exactly PULSE_CYCLES cycles.
- R4: The same accepted 0x08 command sets `irq` to 1 in the following cycle.
- R5: While `por_n` is 0, `cpu_rst_oe` is 1 without waiting for a clock. A low `por_n` also clears any pulse in progress and clears `irq`.
- R6: `irq` stays 1 until an edge samples `irq_clr`=1, and then it reads 0 after that edge. If an accepted command and `irq_clr` arrive at the same edge, `irq` stays 1.
- R7: An accepted 0x08 command that arrives while a pulse is running restarts the count. The pulse then ends PULSE_CYCLES cycles after the restarting edge.
- R8: A command byte other than 0x08, or any byte presented while `cmd_wr` is 0, changes neither `cpu_rst_oe` nor `irq`.
- R9: After `por_n` rises, the first SYNC_STAGES clock edges ignore commands. The first command that takes effect is the one sampled on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low |
| host_rst_n | input | 1 | Host hardware reset, active low |
| sys_rst_bit | input | 1 | System-reset control bit, 0 requests a drive reset |
| cmd_wr | input | 1 | Strobe: a host command byte is presented |
| cmd_byte | input | CMD_W | Host command byte |
| irq_clr | input | 1 | Firmware clear strobe for the interrupt |
| drv_rst_oe | output | 1 | Drive reset line pulled low when 1 |
| drv_rst_o | output | 1 | Drive reset data value, always 0 |
| cpu_rst_oe | output | 1 | Microcontroller reset line pulled low when 1 |
| cpu_rst_o | output | 1 | Microcontroller reset data value, always 0 |
| irq | output | 1 | Interrupt to the microcontroller for a soft reset |

## Verification
The bench builds the block with PULSE_CYCLES = 5 and the default SYNC_STAGES = 2. This makes the exact pulse length and the restart-while-running length short enough to count cycle by cycle. The small configuration also allows a sweep over all 256 command codes and all four combinations of the drive reset inputs. It brings the synchronizer release window within reach too, so the bench can probe the edges on which commands must be ignored.

// File: rtl/drst_pkg.sv
package drst_pkg;
  localparam int unsigned DEF_PULSE_CYCLES  = 33868;
  localparam logic [7:0]  DEF_SOFT_RST_CODE = 8'h08;
  localparam int unsigned DEF_SYNC_STAGES   = 2;

  // request vector positions for the two open-drain merges
  localparam int unsigned DRV_SRC_REG  = 0;
  localparam int unsigned DRV_SRC_HOST = 1;
  localparam int unsigned CPU_SRC_POR  = 0;
  localparam int unsigned CPU_SRC_SOFT = 1;
  localparam int unsigned N_RST_SRC    = 2;
endpackage

// File: rtl/drst_rst_sync.sv
module drst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] q_q;
  logic [STAGES-1:0] q_d;

  generate
    if (STAGES == 1) begin : g_single
      assign q_d = 1'b1;
    end else begin : g_chain
      assign q_d = {q_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q_q <= '0;
    else         q_q <= q_d;
  end

  assign srst_n = q_q[STAGES-1];
endmodule

// File: rtl/drst_cmd_match.sv
module drst_cmd_match #(
  parameter int unsigned     W    = 8,
  parameter logic [W-1:0]    CODE = '0
) (
  input  logic         cmd_wr,
  input  logic [W-1:0] cmd_byte,
  output logic         hit
);
  always_comb begin
    hit = cmd_wr && (cmd_byte == CODE);
  end
endmodule

// File: rtl/drst_pulse_timer.sv
module drst_pulse_timer #(
  parameter int unsigned CYCLES = 33868
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int unsigned      CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD  = CNT_W'(CYCLES);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    active = (cnt_q != '0);
    cnt_en = start || active;
    if (start) cnt_d = LOAD;
    else       cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/drst_irq_latch.sv
module drst_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  logic irq_q;
  logic irq_d;
  logic irq_en;

  always_comb begin
    irq_en = set || clr;
    irq_d  = set;   // set has priority over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/drst_od_merge.sv
module drst_od_merge #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] req,
  output logic         oe,
  output logic         dat
);
  always_comb begin
    oe  = |req;
    dat = 1'b0;
  end
endmodule

// File: rtl/drive_reset_seq.sv
module drive_reset_seq
  import drst_pkg::*;
#(
  parameter int unsigned       PULSE_CYCLES  = DEF_PULSE_CYCLES,
  parameter int unsigned       CMD_W         = 8,
  parameter logic [CMD_W-1:0]  SOFT_RST_CODE = CMD_W'(DEF_SOFT_RST_CODE),
  parameter int unsigned       SYNC_STAGES   = DEF_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             host_rst_n,
  input  logic             sys_rst_bit,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             irq_clr,
  output logic             drv_rst_oe,
  output logic             drv_rst_o,
  output logic             cpu_rst_oe,
  output logic             cpu_rst_o,
  output logic             irq
);
  logic                 rst_ok_n;
  logic                 soft_hit;
  logic                 pulse_on;
  logic [N_RST_SRC-1:0] drv_req;
  logic [N_RST_SRC-1:0] cpu_req;

  drst_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (rst_ok_n)
  );

  drst_cmd_match #(.W(CMD_W), .CODE(SOFT_RST_CODE)) u_match (
    .cmd_wr   (cmd_wr),
    .cmd_byte (cmd_byte),
    .hit      (soft_hit)
  );

  drst_pulse_timer #(.CYCLES(PULSE_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_ok_n),
    .start  (soft_hit),
    .active (pulse_on)
  );

  drst_irq_latch u_irq (
    .clk   (clk),
    .rst_n (rst_ok_n),
    .set   (soft_hit),
    .clr   (irq_clr),
    .irq   (irq)
  );

  always_comb begin
    drv_req               = '0;
    drv_req[DRV_SRC_REG]  = !sys_rst_bit;
    drv_req[DRV_SRC_HOST] = !host_rst_n;
    cpu_req               = '0;
    cpu_req[CPU_SRC_POR]  = !por_n;
    cpu_req[CPU_SRC_SOFT] = pulse_on;
  end

  drst_od_merge #(.N(N_RST_SRC)) u_drv_od (
    .req (drv_req),
    .oe  (drv_rst_oe),
    .dat (drv_rst_o)
  );

  drst_od_merge #(.N(N_RST_SRC)) u_cpu_od (
    .req (cpu_req),
    .oe  (cpu_rst_oe),
    .dat (cpu_rst_o)
  );
endmodule

// File: rtl/drive_reset_seq_chk.sv
module drive_reset_seq_chk #(
  parameter int unsigned      CMD_W         = 8,
  parameter logic [CMD_W-1:0] SOFT_RST_CODE = 8'h08
) (
  input logic             clk,
  input logic             por_n,
  input logic             rst_ok_n,
  input logic             host_rst_n,
  input logic             sys_rst_bit,
  input logic             cmd_wr,
  input logic [CMD_W-1:0] cmd_byte,
  input logic             irq_clr,
  input logic             drv_rst_oe,
  input logic             cpu_rst_oe,
  input logic             irq
);
  logic cmd_is_soft;
  assign cmd_is_soft = cmd_wr && (cmd_byte == SOFT_RST_CODE);

  AST_DRV_PULL: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!host_rst_n || !sys_rst_bit) |-> drv_rst_oe) else $error("AST_DRV_PULL"); // R1
  AST_DRV_FLOAT: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (host_rst_n && sys_rst_bit) |-> !drv_rst_oe) else $error("AST_DRV_FLOAT"); // R2
  AST_SOFT_START: assert property (@(posedge clk) disable iff (!rst_ok_n)
    cmd_is_soft |=> cpu_rst_oe) else $error("AST_SOFT_START"); // R3
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_ok_n)
    cmd_is_soft |=> irq) else $error("AST_IRQ_SET"); // R4
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (irq && !irq_clr) |=> irq) else $error("AST_IRQ_HOLD"); // R6
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $rose(irq) |-> $past(cmd_is_soft)) else $error("AST_IRQ_CAUSE"); // R8
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $rose(cpu_rst_oe) |-> $past(cmd_is_soft)) else $error("AST_PULSE_CAUSE"); // R8

  always @(negedge clk) begin
    if (!por_n) begin
      AST_POR_PASS: assert (cpu_rst_oe) else $error("AST_POR_PASS"); // R5
    end
  end
endmodule

bind drive_reset_seq drive_reset_seq_chk #(
  .CMD_W(CMD_W), .SOFT_RST_CODE(SOFT_RST_CODE)
) u_chk (
  .clk(clk), .por_n(por_n), .rst_ok_n(rst_ok_n), .host_rst_n(host_rst_n),
  .sys_rst_bit(sys_rst_bit), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
  .irq_clr(irq_clr), .drv_rst_oe(drv_rst_oe), .cpu_rst_oe(cpu_rst_oe), .irq(irq)
);

// File: tb/tb_drive_reset_seq.sv
module tb_drive_reset_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 5;
  localparam int SYNC       = 2;

  logic       clk = 1'b0;
  logic       por_n, host_rst_n, sys_rst_bit, cmd_wr, irq_clr;
  logic [7:0] cmd_byte;
  logic       drv_rst_oe, drv_rst_o, cpu_rst_oe, cpu_rst_o, irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drive_reset_seq #(.PULSE_CYCLES(N), .CMD_W(8), .SOFT_RST_CODE(8'h08), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .por_n(por_n), .host_rst_n(host_rst_n), .sys_rst_bit(sys_rst_bit),
    .cmd_wr(cmd_wr), .cmd_byte(cmd_byte), .irq_clr(irq_clr),
    .drv_rst_oe(drv_rst_oe), .drv_rst_o(drv_rst_o),
    .cpu_rst_oe(cpu_rst_oe), .cpu_rst_o(cpu_rst_o), .irq(irq)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // counts cycles with cpu_rst_oe high, starting from the current sample
  task automatic count_pulse(inout int n);
    int guard;
    guard = 0;
    while (cpu_rst_oe && guard < 1000) begin
      step();
      if (cpu_rst_oe) n++;
      guard++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    por_n = 1'b0; host_rst_n = 1'b1; sys_rst_bit = 1'b1;
    cmd_wr = 1'b0; cmd_byte = '0; irq_clr = 1'b0;
    repeat (3) step();
    check("R5 cpu reset during por", int'(cpu_rst_oe), 1);
    check("R5 irq during por", int'(irq), 0);
    check("R2 drive released at reset", int'(drv_rst_oe), 0);
    check("R2 drive data low", int'(drv_rst_o), 0);
    check("R2 cpu data low", int'(cpu_rst_o), 0);

    // R9: commands in the synchronizer window are ignored
    por_n = 1'b1; cmd_wr = 1'b1; cmd_byte = 8'h08;
    #1;
    check("R5 cpu reset follows por release", int'(cpu_rst_oe), 0);
    repeat (SYNC) step();
    cmd_wr = 1'b0;
    check("R9 cmd ignored in sync window pulse", int'(cpu_rst_oe), 0);
    check("R9 cmd ignored in sync window irq", int'(irq), 0);
    step();
    check("R9 still idle", int'(cpu_rst_oe), 0);

    // R1/R2 exhaustive over the two drive reset sources
    for (int h = 0; h < 2; h++) begin
      for (int s = 0; s < 2; s++) begin
        host_rst_n = h[0]; sys_rst_bit = s[0];
        #1;
        if (h == 1 && s == 1) check("R2 drive released", int'(drv_rst_oe), 0);
        else                  check("R1 drive pulled", int'(drv_rst_oe), 1);
        step();
      end
    end
    host_rst_n = 1'b1; sys_rst_bit = 1'b1;

    // R3/R4: single pulse length and interrupt
    cmd_wr = 1'b1; cmd_byte = 8'h08;
    step();
    cmd_wr = 1'b0;
    check("R4 irq after command", int'(irq), 1);
    check("R3 pulse starts", int'(cpu_rst_oe), 1);
    n = 1;
    count_pulse(n);
    check("R3 pulse length", n, N);

    // R6: hold and clear
    repeat (3) step();
    check("R6 irq held", int'(irq), 1);
    irq_clr = 1'b1;
    step();
    irq_clr = 1'b0;
    check("R6 irq cleared", int'(irq), 0);

    // R6: set wins over clear
    cmd_wr = 1'b1; irq_clr = 1'b1;
    step();
    cmd_wr = 1'b0; irq_clr = 1'b0;
    check("R6 set wins over clear", int'(irq), 1);
    repeat (N + 1) step();
    irq_clr = 1'b1; step(); irq_clr = 1'b0;

    // R7: restart during pulse
    cmd_wr = 1'b1;
    step();
    cmd_wr = 1'b0;
    n = 1;
    step(); if (cpu_rst_oe) n++;
    step(); if (cpu_rst_oe) n++;
    cmd_wr = 1'b1;
    step(); if (cpu_rst_oe) n++;
    cmd_wr = 1'b0;
    count_pulse(n);
    check("R7 restarted pulse length", n, N + 3);
    irq_clr = 1'b1; step(); irq_clr = 1'b0;

    // R8: sweep of every other code, and a held 08h without strobe
    for (int c = 0; c < 256; c++) begin
      if (c != 8) begin
        cmd_wr = 1'b1; cmd_byte = 8'(c);
        step();
        cmd_wr = 1'b0;
        if (cpu_rst_oe || irq) check("R8 other code ignored", int'({cpu_rst_oe, irq}), 0);
        else checks++;
      end
    end
    cmd_byte = 8'h08;
    repeat (3) step();
    check("R8 no strobe pulse", int'(cpu_rst_oe), 0);
    check("R8 no strobe irq", int'(irq), 0);

    // R5: por in the middle of a pulse
    cmd_wr = 1'b1;
    step();
    cmd_wr = 1'b0;
    step();
    por_n = 1'b0;
    #1;
    check("R5 por passthrough mid pulse", int'(cpu_rst_oe), 1);
    check("R5 por clears irq", int'(irq), 0);
    step();
    por_n = 1'b1;
    #1;
    check("R5 pulse cleared by por", int'(cpu_rst_oe), 0);
    repeat (N + 2) step();
    check("R5 stays idle after por", int'(cpu_rst_oe), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule